// File: doc/BRIEF.md
# EEPROM Programming Pulse Sequencer

This controller drives the complete programming cycle of an external device whose configuration register is loaded over a serial line and backed by on-chip EEPROM. One start strobe latches a configuration word. The controller then runs a fixed chain of steps. It shifts the word into the device's shadow register. It holds an erase relay enable for a timed window, waits a dead time, and holds a write relay enable for a second timed window. It then verifies the programmed contents.

Verification takes three serial frames. The first is a short frame that writes an enhancement control word with only bit 1 set, which routes the device's data-out pin to the EEPROM-backed register. The other two are identical full-width frames: the first makes the device recall the EEPROM contents into the register, and during the second the device shifts that register out while the controller captures each bit and compares the result with the latched word. All millisecond windows are counted in ticks of `TICK_CYCLES` clock cycles, so a bench can shrink time without changing the sequence. The analog supplies and the relays themselves are outside this block.

Top module: `eeprog_seq`

## Requirements
- R1: After an accepted start the steps run in this fixed order: configuration frame, erase window, dead time, write window, enhancement frame, recall frame, readout frame, then the result flags.
- R2: `erase_en` stays high for exactly `ERASE_MS*TICK_CYCLES` consecutive cycles.
- R3: `write_en` stays high for exactly `WRITE_MS*TICK_CYCLES` consecutive cycles.
- R4: `erase_en` and `write_en` are never high together, and at least `GAP_MS*TICK_CYCLES` cycles with both low separate the end of the erase window from the start of the write window.
- R5: Each frame sends its bits MSB first. `sdata` changes only while `sclk` is low and never while it is high. Each frame ends with `ld_stb` high for exactly one cycle while `sclk` is low. The configuration frame carries the `WORD_W`-bit latched word with `ee_sel` high.
- R6: The enhancement frame is `ENH_W` bits long, carries the value 2 (only bit 1 set) and is sent with `ee_sel` low.
- R7: The recall frame and the readout frame are each `WORD_W` bits of zero data, sent with `ee_sel` high.
- R8: When the sequence ends, `done` rises. At the same time `pass` is set if the word read back equals the latched word, and `fail` is set otherwise. All three flags hold until the next accepted start clears them.
- R9: `prog_n` is low from the cycle after an accepted start until the sequence ends, and high while idle.
- R10: A start pulse that arrives while a sequence is running is ignored. The sequence, its frames and its result are those of the word latched at the original start.
- R11: One cycle after reset is sampled, `erase_en`, `write_en`, `sclk`, `ld_stb`, `done`, `pass` and `fail` are low and `prog_n` is high, even when reset is applied in the middle of an erase window.
- R12: During the readout frame, `sdout_i` is sampled on each rising `sclk` edge and assembled MSB first. A mismatch in either the first or the last bit produces `fail`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a programming cycle when idle |
| cfg_word | input | WORD_W | Configuration word to program |
| sdout_i | input | 1 | Serial data-out line from the device |
| sclk | output | 1 | Serial clock to the device |
| sdata | output | 1 | Serial data to the device |
| ld_stb | output | 1 | One-cycle load strobe after each frame |
| ee_sel | output | 1 | High to address the EEPROM-backed register |
| erase_en | output | 1 | Erase relay enable |
| write_en | output | 1 | Write relay enable |
| prog_n | output | 1 | Enhancement-mode control, low during a cycle |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Read-back matched the word |
| fail | output | 1 | Read-back differed from the word |

## Verification
The duration and dead-time properties assume that every timing parameter is at least one millisecond and that reset lasts at least two cycles, so counter state from an aborted window never reaches a later check. They also assume the device changes `sdout_i` only while `sclk` is low. The bench device model follows this by updating its output only after it sees a falling `sclk`. It holds reset for three cycles, and it applies the mid-sequence start during the dead time, where a wrongly accepted start would show up in both the frames and the result.

// File: rtl/eeprog_pkg.sv
package eeprog_pkg;

    // Bit of the enhancement word that routes data-out to the EEPROM register
    localparam int ENH_VERIFY_BIT = 1;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_ERASE,
        SEQ_GAP,
        SEQ_WRITE,
        SEQ_ENH,
        SEQ_RECALL,
        SEQ_READ
    } seq_state_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_STROBE
    } sh_state_e;

    typedef struct packed {
        logic erase;
        logic write;
        logic sel;
        logic active;
    } seq_ctl_t;

    function automatic seq_ctl_t seq_ctl(input seq_state_e s);
        seq_ctl_t c;
        c.erase  = (s == SEQ_ERASE);
        c.write  = (s == SEQ_WRITE);
        c.sel    = (s == SEQ_LOAD) || (s == SEQ_RECALL) || (s == SEQ_READ);
        c.active = (s != SEQ_IDLE);
        return c;
    endfunction

endpackage

// File: rtl/eeprog_mstimer.sv
module eeprog_mstimer #(
    parameter int TICK_CYCLES = 50000,
    parameter int MS_W        = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic [MS_W-1:0] ms,
    output logic            expired
);
    localparam int SUB_W = $clog2(TICK_CYCLES + 1);

    logic             run;
    logic [SUB_W-1:0] sub;
    logic [MS_W-1:0]  left;

    assign expired = run && (sub == '0) && (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            sub  <= '0;
            left <= '0;
        end else if (arm) begin
            run  <= 1'b1;
            sub  <= SUB_W'(TICK_CYCLES - 1);
            left <= ms - 1'b1;
        end else if (run) begin
            if (sub == '0) begin
                if (left == '0) begin
                    run <= 1'b0;
                end else begin
                    left <= left - 1'b1;
                    sub  <= SUB_W'(TICK_CYCLES - 1);
                end
            end else begin
                sub <= sub - 1'b1;
            end
        end
    end
endmodule

// File: rtl/eeprog_shifter.sv
module eeprog_shifter
    import eeprog_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SCLK_HALF = 4,
    parameter int NB_W      = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [WORD_W-1:0] word,
    input  logic [NB_W-1:0]   nbits,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              strobe,
    output logic              done,
    output logic [WORD_W-1:0] captured
);
    localparam int HC_W = $clog2(SCLK_HALF + 1);

    sh_state_e         st;
    logic [WORD_W-1:0] shreg;
    logic [NB_W-1:0]   left;
    logic [HC_W-1:0]   hcnt;

    assign sdo = shreg[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SH_IDLE;
            shreg    <= '0;
            left     <= '0;
            hcnt     <= '0;
            sclk     <= 1'b0;
            strobe   <= 1'b0;
            done     <= 1'b0;
            captured <= '0;
        end else begin
            strobe <= 1'b0;
            done   <= 1'b0;
            case (st)
                SH_IDLE: begin
                    if (go) begin
                        shreg    <= word << (WORD_W - int'(nbits));
                        left     <= nbits - 1'b1;
                        hcnt     <= HC_W'(SCLK_HALF - 1);
                        captured <= '0;
                        st       <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (hcnt == '0) begin
                        sclk     <= 1'b1;
                        captured <= {captured[WORD_W-2:0], sdi};
                        hcnt     <= HC_W'(SCLK_HALF - 1);
                        st       <= SH_HIGH;
                    end else begin
                        hcnt <= hcnt - 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (hcnt == '0) begin
                        sclk <= 1'b0;
                        hcnt <= HC_W'(SCLK_HALF - 1);
                        if (left == '0) begin
                            strobe <= 1'b1;
                            shreg  <= '0;
                            st     <= SH_STROBE;
                        end else begin
                            shreg <= shreg << 1;
                            left  <= left - 1'b1;
                            st    <= SH_LOW;
                        end
                    end else begin
                        hcnt <= hcnt - 1'b1;
                    end
                end
                default: begin
                    done <= 1'b1;
                    st   <= SH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/eeprog_seq.sv
module eeprog_seq
    import eeprog_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int TICK_CYCLES = CLK_HZ / 1000,
    parameter int WORD_W      = 16,
    parameter int ENH_W       = 8,
    parameter int SCLK_HALF   = 4,
    parameter int ERASE_MS    = 25,
    parameter int WRITE_MS    = 25,
    parameter int GAP_MS      = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              sdout_i,
    output logic              sclk,
    output logic              sdata,
    output logic              ld_stb,
    output logic              ee_sel,
    output logic              erase_en,
    output logic              write_en,
    output logic              prog_n,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    localparam int NB_W   = $clog2(WORD_W + 1);
    localparam int MS_EW  = (ERASE_MS > WRITE_MS) ? ERASE_MS : WRITE_MS;
    localparam int MS_MAX = (GAP_MS > MS_EW) ? GAP_MS : MS_EW;
    localparam int MS_W   = $clog2(MS_MAX + 1);
    localparam logic [WORD_W-1:0] ENH_WORD = WORD_W'(1) << ENH_VERIFY_BIT;

    seq_state_e        state;
    seq_ctl_t          ctl;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] sh_word;
    logic [WORD_W-1:0] sh_cap;
    logic [NB_W-1:0]   sh_nbits;
    logic              sh_go;
    logic              sh_done;
    logic              tm_arm;
    logic              tm_exp;
    logic [MS_W-1:0]   tm_ms;
    logic              done_q;
    logic              pass_q;
    logic              fail_q;

    // Timer is armed on the transition edge so each window runs exactly ms*TICK cycles
    always_comb begin
        tm_arm = 1'b0;
        tm_ms  = '0;
        case (state)
            SEQ_LOAD:  if (sh_done) begin tm_arm = 1'b1; tm_ms = MS_W'(ERASE_MS); end
            SEQ_ERASE: if (tm_exp)  begin tm_arm = 1'b1; tm_ms = MS_W'(GAP_MS);   end
            SEQ_GAP:   if (tm_exp)  begin tm_arm = 1'b1; tm_ms = MS_W'(WRITE_MS); end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            word_q   <= '0;
            sh_go    <= 1'b0;
            sh_word  <= '0;
            sh_nbits <= '0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            sh_go <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        word_q   <= cfg_word;
                        done_q   <= 1'b0;
                        pass_q   <= 1'b0;
                        fail_q   <= 1'b0;
                        sh_go    <= 1'b1;
                        sh_word  <= cfg_word;
                        sh_nbits <= NB_W'(WORD_W);
                        state    <= SEQ_LOAD;
                    end
                end
                SEQ_LOAD:  if (sh_done) state <= SEQ_ERASE;
                SEQ_ERASE: if (tm_exp)  state <= SEQ_GAP;
                SEQ_GAP:   if (tm_exp)  state <= SEQ_WRITE;
                SEQ_WRITE: begin
                    if (tm_exp) begin
                        sh_go    <= 1'b1;
                        sh_word  <= ENH_WORD;
                        sh_nbits <= NB_W'(ENH_W);
                        state    <= SEQ_ENH;
                    end
                end
                SEQ_ENH: begin
                    if (sh_done) begin
                        sh_go    <= 1'b1;
                        sh_word  <= '0;
                        sh_nbits <= NB_W'(WORD_W);
                        state    <= SEQ_RECALL;
                    end
                end
                SEQ_RECALL: begin
                    if (sh_done) begin
                        sh_go    <= 1'b1;
                        sh_word  <= '0;
                        sh_nbits <= NB_W'(WORD_W);
                        state    <= SEQ_READ;
                    end
                end
                SEQ_READ: begin
                    if (sh_done) begin
                        done_q <= 1'b1;
                        pass_q <= (sh_cap == word_q);
                        fail_q <= (sh_cap != word_q);
                        state  <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    eeprog_shifter #(
        .WORD_W   (WORD_W),
        .SCLK_HALF(SCLK_HALF),
        .NB_W     (NB_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (sh_go),
        .word    (sh_word),
        .nbits   (sh_nbits),
        .sdi     (sdout_i),
        .sclk    (sclk),
        .sdo     (sdata),
        .strobe  (ld_stb),
        .done    (sh_done),
        .captured(sh_cap)
    );

    eeprog_mstimer #(
        .TICK_CYCLES(TICK_CYCLES),
        .MS_W       (MS_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (tm_arm),
        .ms     (tm_ms),
        .expired(tm_exp)
    );

    assign ctl      = seq_ctl(state);
    assign erase_en = ctl.erase;
    assign write_en = ctl.write;
    assign ee_sel   = ctl.sel;
    assign prog_n   = !ctl.active;
    assign done     = done_q;
    assign pass     = pass_q;
    assign fail     = fail_q;
endmodule

// File: rtl/eeprog_seq_chk.sv
module eeprog_seq_chk #(
    parameter int TICK_CYCLES = 50000,
    parameter int ERASE_MS    = 25,
    parameter int WRITE_MS    = 25,
    parameter int GAP_MS      = 100
) (
    input logic clk,
    input logic rst,
    input logic erase_en,
    input logic write_en,
    input logic ld_stb,
    input logic sclk,
    input logic sdata,
    input logic prog_n,
    input logic done,
    input logic pass,
    input logic fail
);
    localparam int ERASE_CYC = ERASE_MS * TICK_CYCLES;
    localparam int WRITE_CYC = WRITE_MS * TICK_CYCLES;
    localparam int GAP_CYC   = GAP_MS * TICK_CYCLES;

    int er_len;
    int wr_len;
    int gap_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            er_len  <= 0;
            wr_len  <= 0;
            gap_len <= 0;
        end else begin
            er_len  <= erase_en ? er_len + 1 : 0;
            wr_len  <= write_en ? wr_len + 1 : 0;
            if (erase_en)
                gap_len <= 0;
            else if (!write_en)
                gap_len <= gap_len + 1;
        end
    end

    assert_relays_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(erase_en && write_en));

    assert_dead_time_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(write_en) |-> gap_len >= GAP_CYC);

    assert_erase_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(erase_en) |-> er_len == ERASE_CYC);

    assert_write_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(write_en) |-> wr_len == WRITE_CYC);

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        ld_stb |=> !ld_stb);

    assert_strobe_clk_low_R5: assert property (@(posedge clk) disable iff (rst)
        ld_stb |-> !sclk);

    assert_sdata_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdata));

    assert_prog_low_R9: assert property (@(posedge clk) disable iff (rst)
        (erase_en || write_en || ld_stb) |-> !prog_n);

    assert_flags_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass ^ fail));

    assert_flags_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> !(pass || fail));
endmodule

bind eeprog_seq eeprog_seq_chk #(
    .TICK_CYCLES(TICK_CYCLES),
    .ERASE_MS   (ERASE_MS),
    .WRITE_MS   (WRITE_MS),
    .GAP_MS     (GAP_MS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .erase_en(erase_en),
    .write_en(write_en),
    .ld_stb  (ld_stb),
    .sclk    (sclk),
    .sdata   (sdata),
    .prog_n  (prog_n),
    .done    (done),
    .pass    (pass),
    .fail    (fail)
);

// File: tb/eeprog_seq_test.sv
`timescale 1ns/1ps
module eeprog_seq_test;
    localparam int WORD_W = 16;
    localparam int ENH_W  = 8;
    localparam int TICK   = 4;
    localparam int HALF   = 2;
    localparam int ER     = 25;
    localparam int WR     = 25;
    localparam int GP     = 100;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [WORD_W-1:0] cfg_word = '0;
    logic              sdout_i = 1'b0;
    logic sclk, sdata, ld_stb, ee_sel, erase_en, write_en, prog_n, done, pass, fail;

    eeprog_seq #(
        .CLK_HZ(200_000_000), .TICK_CYCLES(TICK), .WORD_W(WORD_W), .ENH_W(ENH_W),
        .SCLK_HALF(HALF), .ERASE_MS(ER), .WRITE_MS(WR), .GAP_MS(GP)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .cfg_word(cfg_word), .sdout_i(sdout_i),
        .sclk(sclk), .sdata(sdata), .ld_stb(ld_stb), .ee_sel(ee_sel),
        .erase_en(erase_en), .write_en(write_en), .prog_n(prog_n),
        .done(done), .pass(pass), .fail(fail)
    );

    typedef struct {
        bit                sel;
        int                nbits;
        logic [WORD_W-1:0] val;
        string             tag;
    } frame_t;

    frame_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Device model and monitor, both sampling on the falling clock edge
    logic [WORD_W-1:0] dev_mem = '0;
    int   dev_idx = 0;
    logic sclk_prev = 1'b0, sdata_prev = 1'b0, er_prev = 1'b0, wr_prev = 1'b0;
    logic [WORD_W-1:0] mon_bits = '0;
    int   mon_n = 0;
    bit   mon_sel = 0, sel_bad = 0, stab_bad = 0, gap_on = 0;
    int   er_len = 0, wr_len = 0, gap_len = 0;
    int   frames_seen = 0, erase_rises = 0, overlap = 0;
    int   run_base = 0;

    always @(negedge clk) begin
        if (rst) begin
            dev_idx = 0; sclk_prev = 0; sdata_prev = 0; er_prev = 0; wr_prev = 0;
            mon_bits = '0; mon_n = 0; sel_bad = 0; stab_bad = 0; gap_on = 0;
            er_len = 0; wr_len = 0; gap_len = 0;
        end else begin
            if (erase_en && write_en) overlap++;
            if (erase_en && !er_prev) begin
                erase_rises++;
                check(frames_seen - run_base == 1, "R1", "frames before erase",
                      frames_seen - run_base, 1);
            end
            if (erase_en) er_len++;
            else if (er_prev) begin
                check(er_len == ER * TICK, "R2", "erase length", er_len, ER * TICK);
                er_len = 0; gap_len = 0; gap_on = 1;
            end
            if (gap_on && !erase_en && !write_en) gap_len++;
            if (write_en && !wr_prev) begin
                check(gap_len >= GP * TICK, "R4", "dead time", gap_len, GP * TICK);
                check(frames_seen - run_base == 1, "R1", "frames before write",
                      frames_seen - run_base, 1);
                gap_on = 0;
            end
            if (write_en) wr_len++;
            else if (wr_prev) begin
                check(wr_len == WR * TICK, "R3", "write length", wr_len, WR * TICK);
                wr_len = 0;
            end
            if (sclk && !sclk_prev) begin
                mon_bits = {mon_bits[WORD_W-2:0], sdata};
                if (mon_n == 0) mon_sel = ee_sel;
                else if (ee_sel != mon_sel) sel_bad = 1;
                mon_n++;
            end
            if (sclk && sclk_prev && (sdata != sdata_prev)) stab_bad = 1;
            if (!sclk && sclk_prev) dev_idx++;
            if (ld_stb) begin
                if (exp_q.size() == 0) begin
                    check(0, "R1", "unexpected frame", mon_bits, 0);
                end else begin
                    frame_t f;
                    f = exp_q.pop_front();
                    check(mon_n == f.nbits, f.tag, "frame length", mon_n, f.nbits);
                    check(mon_bits == f.val, f.tag, "frame data", mon_bits, f.val);
                    check(mon_sel == f.sel && !sel_bad, f.tag, "frame select", mon_sel, f.sel);
                    check(!stab_bad, "R5", "sdata stable while sclk high", stab_bad, 0);
                end
                frames_seen++;
                dev_idx = 0; mon_n = 0; mon_bits = '0; sel_bad = 0; stab_bad = 0;
            end
            er_prev = erase_en; wr_prev = write_en;
            sclk_prev = sclk; sdata_prev = sdata;
        end
        sdout_i = (dev_idx < WORD_W) ? dev_mem[WORD_W-1-dev_idx] : 1'b0;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_frames(input logic [WORD_W-1:0] w);
        exp_q.push_back('{1'b1, WORD_W, w, "R5"});
        exp_q.push_back('{1'b0, ENH_W, WORD_W'(2), "R6"});
        exp_q.push_back('{1'b1, WORD_W, '0, "R7"});
        exp_q.push_back('{1'b1, WORD_W, '0, "R7"});
    endtask

    // Driver: queues the expected frames, strobes start, then checks the result
    task automatic run_prog(input logic [WORD_W-1:0] w, input logic [WORD_W-1:0] mem,
                            input bit exp_pass, input bit poke_busy, input string rtag);
        int er_base;
        dev_mem  = mem;
        run_base = frames_seen;
        er_base  = erase_rises;
        push_frames(w);
        cfg_word = w;
        start    = 1'b1;
        tick();
        start    = 1'b0;
        check(prog_n == 1'b0, "R9", "prog_n low after start", prog_n, 0);
        check(done == 1'b0, "R8", "done cleared by start", done, 0);
        if (poke_busy) begin
            while (!erase_en) tick();
            while (erase_en) tick();
            cfg_word = ~w;
            start    = 1'b1;
            tick();
            start    = 1'b0;
        end
        while (!done) tick();
        check(frames_seen - run_base == 4, "R1", "frames at done", frames_seen - run_base, 4);
        check(pass == exp_pass && fail == !exp_pass, rtag, "pass/fail",
              {pass, fail}, {exp_pass, !exp_pass});
        check(prog_n == 1'b1, "R9", "prog_n high when idle", prog_n, 1);
        if (poke_busy)
            check(erase_rises - er_base == 1, "R10", "erase windows per run",
                  erase_rises - er_base, 1);
        tick(); tick();
        check(done && (pass == exp_pass), "R8", "flags held", {done, pass}, {1'b1, exp_pass});
        check(exp_q.size() == 0, "R1", "frames left over", exp_q.size(), 0);
    endtask

    task automatic check_reset_state(input string what);
        check(!erase_en && !write_en, "R11", {what, " relays"}, {erase_en, write_en}, 0);
        check(!sclk && !ld_stb, "R11", {what, " serial"}, {sclk, ld_stb}, 0);
        check(!done && !pass && !fail, "R11", {what, " flags"}, {done, pass, fail}, 0);
        check(prog_n == 1'b1, "R11", {what, " prog_n"}, prog_n, 1);
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) tick();
        check_reset_state("initial reset");
        rst = 1'b0;
        tick();
        check_reset_state("after reset release");

        // R8 R12: asymmetric word read back intact
        run_prog(16'hA5C3, 16'hA5C3, 1'b1, 1'b0, "R12");
        // R10: start during the dead time with a different word
        run_prog(16'h1234, 16'h1234, 1'b1, 1'b1, "R10");
        // R12: last bit differs
        run_prog(16'hFFFF, 16'hFFFE, 1'b0, 1'b0, "R12");
        // R12: first bit differs
        run_prog(16'h0001, 16'h8001, 1'b0, 1'b0, "R12");

        // R11: reset in the middle of the erase window
        dev_mem  = 16'h0F0F;
        run_base = frames_seen;
        exp_q.push_back('{1'b1, WORD_W, 16'h0F0F, "R5"});
        cfg_word = 16'h0F0F;
        start    = 1'b1;
        tick();
        start    = 1'b0;
        while (!erase_en) tick();
        repeat (10) tick();
        rst = 1'b1;
        tick();
        check_reset_state("mid-erase reset");
        repeat (2) tick();
        rst = 1'b0;
        exp_q.delete();
        tick();
        check_reset_state("after mid-erase reset");

        // Recovery run after the abort
        run_prog(16'h0000, 16'h0000, 1'b1, 1'b0, "R8");

        check(overlap == 0, "R4", "relay overlap cycles", overlap, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule